// File: doc/BRIEF.md
# Software-Reloaded Translation Buffer

This block keeps recently used address translations for a processor that refills them entirely from software. It holds two independent buffers, one for instruction fetches and one for data accesses. Each buffer is two-way set-associative. A requester presents an effective address together with a compare word that was derived from it (valid flag, segment identifier, hash-select flag and abbreviated page index). One clock later the block answers with a hit, the physical address and the stored real-page word, or with a miss that carries the access type.

There is no hardware walker. On a miss, exception software searches the page table and then issues a load command for the buffer concerned. The command names an effective address, whose page-number bits select the set, and a way-select bit. It writes a new compare word and real-page word into that entry. A store that hits an entry whose changed bit is still clear is answered as a store miss, so that software can set the changed bit in memory. An invalidate-all input empties both buffers in one cycle.

Top module: `xlat_sw_tlb`

## Requirements
- R1: After synchronous reset every entry of both buffers is invalid and no response is pending. Every lookup misses until a load has filled an entry.
- R2: A lookup request without a load on the same side in the same cycle gives exactly one response in the next cycle (`*_rsp_valid` high), with exactly one of hit or miss high. When no lookup is accepted, valid, hit and miss are all low in the next cycle.
- R3: Compare word layout: bit 31 valid, bits 30:7 segment identifier, bit 6 hash-select flag, bits 5:0 abbreviated page index. A lookup hits when the selected entry is valid and its bits 30:0 equal the lookup word's bits 30:0. Bit 31 of the lookup word is ignored.
- R4: Real-page word layout: bits 31:12 real page number, bit 8 referenced, bit 7 changed, bits 6:3 cache/memory attributes, bits 1:0 protection; bits 11:9 and 2 are spare. On a hit the physical address is the real page number followed by effective-address bits 11:0, and the stored real-page word is returned.
- R5: A load writes its compare word and real-page word into the set selected by load-address bits 19:15, in way 0 or way 1 as chosen by the way-select input. The entry becomes valid exactly when bit 31 of the loaded compare word is 1. The other way and the other sets are left unchanged.
- R6: The fetch and data buffers are separate. A load into one is never seen by lookups on the other.
- R7: The access-type output is 00 for fetch, 01 for data load and 10 for data store, on both hits and misses. It is 00 when no response is valid.
- R8: A data store that matches an entry whose changed bit (real-page word bit 7) is 0 is answered as a miss of type store. A data load that matches the same entry hits.
- R9: Invalidate-all clears every entry of both buffers at the clock edge and overrides any load in that cycle. A lookup in that same cycle still sees the contents from before the edge.
- R10: When a load and a lookup arrive on the same side in the same cycle, the load is performed and that lookup is dropped, so no response follows.
- R11: When both ways of a set match the lookup, the entry in way 0 is returned.
- R12: Whenever the hit output is low, the physical address and real-page word outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Invalidate every entry of both buffers |
| f_req | input | 1 | Fetch lookup request |
| f_ea | input | 32 | Fetch effective address |
| f_cmp | input | 32 | Fetch compare word |
| f_ld | input | 1 | Fetch buffer load command |
| f_ld_ea | input | 32 | Fetch load address (set select) |
| f_ld_way | input | 1 | Fetch load way select |
| f_ld_cmp | input | 32 | Fetch load compare word |
| f_ld_rpw | input | 32 | Fetch load real-page word |
| f_rsp_valid | output | 1 | Fetch response valid |
| f_hit | output | 1 | Fetch hit |
| f_miss | output | 1 | Fetch miss |
| f_kind | output | 2 | Fetch access type (always 00) |
| f_pa | output | 32 | Fetch physical address |
| f_rpw | output | 32 | Fetch real-page word of the hit |
| d_req | input | 1 | Data lookup request |
| d_store | input | 1 | Data access is a store |
| d_ea | input | 32 | Data effective address |
| d_cmp | input | 32 | Data compare word |
| d_ld | input | 1 | Data buffer load command |
| d_ld_ea | input | 32 | Data load address (set select) |
| d_ld_way | input | 1 | Data load way select |
| d_ld_cmp | input | 32 | Data load compare word |
| d_ld_rpw | input | 32 | Data load real-page word |
| d_rsp_valid | output | 1 | Data response valid |
| d_hit | output | 1 | Data hit |
| d_miss | output | 1 | Data miss (load or store) |
| d_kind | output | 2 | Data access type |
| d_pa | output | 32 | Data physical address |
| d_rpw | output | 32 | Data real-page word of the hit |

## Verification
The assertions assume that the request, store and load strobes are low while reset is held. They also assume the store qualifier has a defined value whenever a data lookup is requested. The bench holds every strobe low through reset and drives all inputs on the falling edge, so each cycle presents one clean set of strobes. Its random phase draws compare words from a small pool and effective addresses from a few sets. That makes duplicate matches, overwrites and invalidates overlap with lookups while staying inside those assumptions.

// File: rtl/xlat_tlb_pkg.sv
`timescale 1ns/1ps
package xlat_tlb_pkg;

  localparam int XT_EA_W   = 32;
  localparam int XT_PG_OFF = 12;
  localparam int XT_RPN_W  = XT_EA_W - XT_PG_OFF;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10
  } acc_e;

  typedef struct packed {
    logic        v;
    logic [23:0] vsid;
    logic        hsel;
    logic [5:0]  api;
  } cmp_word_t;

  typedef struct packed {
    logic [XT_RPN_W-1:0] rpn;
    logic [2:0]          spare_hi;
    logic                refd;
    logic                chg;
    logic [3:0]          wimg;
    logic                spare_lo;
    logic [1:0]          pp;
  } real_word_t;

  localparam int XT_CMP_W = $bits(cmp_word_t);
  localparam int XT_RPW_W = $bits(real_word_t);

endpackage

// File: rtl/xlat_tlb_way.sv
`timescale 1ns/1ps
module xlat_tlb_way
  import xlat_tlb_pkg::*;
#(
  parameter int SETS  = 32,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  cmp_word_t        wcmp,
  input  real_word_t       wrpw,
  input  logic [IDX_W-1:0] ridx,
  output logic             rvld,
  output cmp_word_t        rcmp,
  output real_word_t       rrpw
);

  localparam int ENT_W = XT_CMP_W + XT_RPW_W;

  logic [ENT_W-1:0] mem [SETS];
  logic [SETS-1:0]  vld;

  // word storage: no reset, single write port, so it can map to RAM
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= {wcmp, wrpw};
  end

  // valid flags in flops so that a flash clear takes one cycle
  always_ff @(posedge clk) begin
    if (rst || inv) vld <= '0;
    else if (we)    vld[widx] <= wcmp.v;
  end

  assign {rcmp, rrpw} = mem[ridx];
  assign rvld         = vld[ridx];

  a_r9_flash_clear: assert property (@(posedge clk) disable iff (rst)
    inv |=> (vld == '0));

  a_r5_valid_follows_load: assert property (@(posedge clk) disable iff (rst)
    (we && !inv) |=> (vld[$past(widx)] == $past(wcmp.v)));

endmodule

// File: rtl/xlat_tlb_match.sv
`timescale 1ns/1ps
module xlat_tlb_match
  import xlat_tlb_pkg::*;
#(
  parameter int WAYS = 2
) (
  input  cmp_word_t               lk,
  input  logic      [WAYS-1:0]    way_vld,
  input  cmp_word_t [WAYS-1:0]    way_cmp,
  input  real_word_t [WAYS-1:0]   way_rpw,
  output logic                    any_hit,
  output real_word_t              sel_rpw
);

  logic [WAYS-1:0] hitv;
  logic [WAYS-1:0] unused_vbits;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitv[w] = way_vld[w]
                  && (way_cmp[w].vsid == lk.vsid)
                  && (way_cmp[w].hsel == lk.hsel)
                  && (way_cmp[w].api  == lk.api);
    assign unused_vbits[w] = way_cmp[w].v ^ lk.v;
  end

  // lowest-numbered matching way wins
  always_comb begin
    sel_rpw = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitv[w]) sel_rpw = way_rpw[w];
    end
  end

  assign any_hit = |hitv;

endmodule

// File: rtl/xlat_tlb_core.sv
`timescale 1ns/1ps
module xlat_tlb_core
  import xlat_tlb_pkg::*;
#(
  parameter int SETS    = 32,
  parameter int WAYS    = 2,
  parameter int IDX_LSB = 15,
  parameter bit IS_DATA = 1'b0,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inv,
  input  logic               req,
  input  logic               store,
  input  logic [XT_EA_W-1:0] ea,
  input  cmp_word_t          cmp,
  input  logic               ld,
  input  logic [XT_EA_W-1:0] ld_ea,
  input  logic [WAY_W-1:0]   ld_way,
  input  cmp_word_t          ld_cmp,
  input  real_word_t         ld_rpw,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic [1:0]         rsp_kind,
  output logic [XT_EA_W-1:0] rsp_pa,
  output real_word_t         rsp_rpw
);

  logic [IDX_W-1:0]        rd_idx;
  logic [IDX_W-1:0]        wr_idx;
  logic [WAYS-1:0]         w_vld;
  cmp_word_t [WAYS-1:0]    w_cmp;
  real_word_t [WAYS-1:0]   w_rpw;
  logic                    any_hit;
  real_word_t              sel_rpw;
  logic                    take;
  logic                    chg_block;
  logic                    hit_n;
  acc_e                    kind_n;
  logic                    unused_ea;

  assign rd_idx    = ea[IDX_LSB +: IDX_W];
  assign wr_idx    = ld_ea[IDX_LSB +: IDX_W];
  assign unused_ea = ^{ea, ld_ea};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    xlat_tlb_way #(.SETS(SETS)) i_way (
      .clk  (clk),
      .rst  (rst),
      .inv  (inv),
      .we   (ld && !inv && (ld_way == WAY_W'(w))),
      .widx (wr_idx),
      .wcmp (ld_cmp),
      .wrpw (ld_rpw),
      .ridx (rd_idx),
      .rvld (w_vld[w]),
      .rcmp (w_cmp[w]),
      .rrpw (w_rpw[w])
    );
  end

  xlat_tlb_match #(.WAYS(WAYS)) i_match (
    .lk      (cmp),
    .way_vld (w_vld),
    .way_cmp (w_cmp),
    .way_rpw (w_rpw),
    .any_hit (any_hit),
    .sel_rpw (sel_rpw)
  );

  if (IS_DATA) begin : g_data
    assign kind_n    = store ? ACC_STORE : ACC_LOAD;
    assign chg_block = store && !sel_rpw.chg;
  end else begin : g_fetch
    assign kind_n    = ACC_FETCH;
    assign chg_block = 1'b0;
  end

  assign take  = req && !ld;
  assign hit_n = any_hit && !chg_block;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_kind  <= ACC_FETCH;
      rsp_pa    <= '0;
      rsp_rpw   <= '0;
    end else begin
      rsp_valid <= take;
      rsp_hit   <= take && hit_n;
      rsp_miss  <= take && !hit_n;
      rsp_kind  <= take ? kind_n : ACC_FETCH;
      rsp_pa    <= (take && hit_n) ? {sel_rpw.rpn, ea[XT_PG_OFF-1:0]} : '0;
      rsp_rpw   <= (take && hit_n) ? sel_rpw : '0;
    end
  end

  a_r2_req_answered: assert property (@(posedge clk) disable iff (rst)
    (req && !ld) |=> rsp_valid);

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit ^ rsp_miss));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss));

  a_r10_load_drops_lookup: assert property (@(posedge clk) disable iff (rst)
    ld |=> !rsp_valid);

  a_r4_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (req && !ld) |=> (!rsp_hit || (rsp_pa[XT_PG_OFF-1:0] == $past(ea[XT_PG_OFF-1:0]))));

  a_r8_store_needs_chg: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit && (rsp_kind == ACC_STORE)) |-> rsp_rpw.chg);

  a_r12_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> ((rsp_pa == '0) && (rsp_rpw == '0)));

  a_r9_miss_after_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(inv) && req && !ld) |=> rsp_miss);

  a_r7_fetch_kind: assert property (@(posedge clk) disable iff (rst)
    (!IS_DATA || !rsp_valid) |-> (rsp_kind == ACC_FETCH));

endmodule

// File: rtl/xlat_sw_tlb.sv
`timescale 1ns/1ps
module xlat_sw_tlb #(
  parameter int SETS    = 32,
  parameter int WAYS    = 2,
  parameter int IDX_LSB = 15,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv_all,
  input  logic             f_req,
  input  logic [31:0]      f_ea,
  input  logic [31:0]      f_cmp,
  input  logic             f_ld,
  input  logic [31:0]      f_ld_ea,
  input  logic [WAY_W-1:0] f_ld_way,
  input  logic [31:0]      f_ld_cmp,
  input  logic [31:0]      f_ld_rpw,
  output logic             f_rsp_valid,
  output logic             f_hit,
  output logic             f_miss,
  output logic [1:0]       f_kind,
  output logic [31:0]      f_pa,
  output logic [31:0]      f_rpw,
  input  logic             d_req,
  input  logic             d_store,
  input  logic [31:0]      d_ea,
  input  logic [31:0]      d_cmp,
  input  logic             d_ld,
  input  logic [31:0]      d_ld_ea,
  input  logic [WAY_W-1:0] d_ld_way,
  input  logic [31:0]      d_ld_cmp,
  input  logic [31:0]      d_ld_rpw,
  output logic             d_rsp_valid,
  output logic             d_hit,
  output logic             d_miss,
  output logic [1:0]       d_kind,
  output logic [31:0]      d_pa,
  output logic [31:0]      d_rpw
);

  xlat_tlb_core #(
    .SETS(SETS), .WAYS(WAYS), .IDX_LSB(IDX_LSB), .IS_DATA(1'b0)
  ) i_fetch (
    .clk       (clk),
    .rst       (rst),
    .inv       (inv_all),
    .req       (f_req),
    .store     (1'b0),
    .ea        (f_ea),
    .cmp       (f_cmp),
    .ld        (f_ld),
    .ld_ea     (f_ld_ea),
    .ld_way    (f_ld_way),
    .ld_cmp    (f_ld_cmp),
    .ld_rpw    (f_ld_rpw),
    .rsp_valid (f_rsp_valid),
    .rsp_hit   (f_hit),
    .rsp_miss  (f_miss),
    .rsp_kind  (f_kind),
    .rsp_pa    (f_pa),
    .rsp_rpw   (f_rpw)
  );

  xlat_tlb_core #(
    .SETS(SETS), .WAYS(WAYS), .IDX_LSB(IDX_LSB), .IS_DATA(1'b1)
  ) i_data (
    .clk       (clk),
    .rst       (rst),
    .inv       (inv_all),
    .req       (d_req),
    .store     (d_store),
    .ea        (d_ea),
    .cmp       (d_cmp),
    .ld        (d_ld),
    .ld_ea     (d_ld_ea),
    .ld_way    (d_ld_way),
    .ld_cmp    (d_ld_cmp),
    .ld_rpw    (d_ld_rpw),
    .rsp_valid (d_rsp_valid),
    .rsp_hit   (d_hit),
    .rsp_miss  (d_miss),
    .rsp_kind  (d_kind),
    .rsp_pa    (d_pa),
    .rsp_rpw   (d_rpw)
  );

endmodule

// File: tb/test_xlat_sw_tlb.sv
`timescale 1ns/1ps
module test_xlat_sw_tlb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic inv_all;
  logic f_req, f_ld, f_ld_way;
  logic [31:0] f_ea, f_cmp, f_ld_ea, f_ld_cmp, f_ld_rpw;
  logic f_rsp_valid, f_hit, f_miss;
  logic [1:0] f_kind;
  logic [31:0] f_pa, f_rpw;
  logic d_req, d_store, d_ld, d_ld_way;
  logic [31:0] d_ea, d_cmp, d_ld_ea, d_ld_cmp, d_ld_rpw;
  logic d_rsp_valid, d_hit, d_miss;
  logic [1:0] d_kind;
  logic [31:0] d_pa, d_rpw;

  xlat_sw_tlb i_xlat_sw_tlb (.*);

  int n_checks = 0;
  int n_fail   = 0;

  // reference contents: [side][set][way], side 0 = fetch, 1 = data
  logic        m_vld [2][32][2];
  logic [31:0] m_cmp [2][32][2];
  logic [31:0] m_rpw [2][32][2];

  function automatic logic [31:0] mk_cmp(logic v, logic [23:0] vsid, logic h, logic [5:0] api);
    return {v, vsid, h, api};
  endfunction

  function automatic logic [31:0] mk_rpw(logic [19:0] rpn, logic c, logic [3:0] wimg, logic [1:0] pp);
    return {rpn, 3'b000, 1'b1, c, wimg, 1'b0, pp};
  endfunction

  function automatic logic [31:0] mk_ea(logic [11:0] hi, logic [4:0] set, logic [14:0] lo);
    return {hi, set, lo};
  endfunction

  // expected {valid, hit, miss, kind, pa, rpw} one cycle after the inputs
  function automatic logic [68:0] predict(int s, logic req, logic ld, logic st,
                                          logic [31:0] ea, logic [31:0] cmp,
                                          output string tag);
    int set = int'(ea[19:15]);
    int found = -1;
    int nmatch = 0;
    logic [1:0] kind;
    if (!req || ld) begin
      tag = ld && req ? "R10" : "R2";
      return '0;
    end
    for (int w = 1; w >= 0; w--) begin
      if (m_vld[s][set][w] && (m_cmp[s][set][w][30:0] == cmp[30:0])) begin
        found = w;
        nmatch++;
      end
    end
    kind = (s == 0) ? 2'b00 : (st ? 2'b10 : 2'b01);
    if (found >= 0 && !(s == 1 && st && !m_rpw[s][set][found][7])) begin
      tag = (nmatch > 1) ? "R11" : "R3 R4 R5";
      return {1'b1, 1'b1, 1'b0, kind, m_rpw[s][set][found][31:12], ea[11:0], m_rpw[s][set][found]};
    end
    tag = (found >= 0) ? "R8" : ((s == 1) ? "R7" : "R3");
    return {1'b1, 1'b0, 1'b1, kind, 64'd0};
  endfunction

  task automatic idle();
    inv_all = 0;
    f_req = 0; f_ld = 0; f_ld_way = 0;
    f_ea = 0; f_cmp = 0; f_ld_ea = 0; f_ld_cmp = 0; f_ld_rpw = 0;
    d_req = 0; d_store = 0; d_ld = 0; d_ld_way = 0;
    d_ea = 0; d_cmp = 0; d_ld_ea = 0; d_ld_cmp = 0; d_ld_rpw = 0;
  endtask

  task automatic fq(logic [31:0] ea, logic [31:0] cmp);
    f_req = 1; f_ea = ea; f_cmp = cmp;
  endtask
  task automatic dq(logic [31:0] ea, logic [31:0] cmp, logic st);
    d_req = 1; d_ea = ea; d_cmp = cmp; d_store = st;
  endtask
  task automatic fl(logic [31:0] ea, logic way, logic [31:0] cmp, logic [31:0] rpw);
    f_ld = 1; f_ld_ea = ea; f_ld_way = way; f_ld_cmp = cmp; f_ld_rpw = rpw;
  endtask
  task automatic dl(logic [31:0] ea, logic way, logic [31:0] cmp, logic [31:0] rpw);
    d_ld = 1; d_ld_ea = ea; d_ld_way = way; d_ld_cmp = cmp; d_ld_rpw = rpw;
  endtask

  task automatic compare(string side, string tag, logic [68:0] got, logic [68:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, side, got, exp);
    end
  endtask

  // one clock: predict, update the model, advance, compare, return to idle
  task automatic tick(string note);
    string tf, td;
    logic [68:0] ef, ed;
    ef = predict(0, f_req, f_ld, 1'b0, f_ea, f_cmp, tf);
    ed = predict(1, d_req, d_ld, d_store, d_ea, d_cmp, td);
    if (note != "") begin
      tf = note;
      td = note;
    end
    if (inv_all) begin
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 32; i++)
          for (int w = 0; w < 2; w++) m_vld[s][i][w] = 1'b0;
    end else begin
      if (f_ld) begin
        m_vld[0][f_ld_ea[19:15]][f_ld_way] = f_ld_cmp[31];
        m_cmp[0][f_ld_ea[19:15]][f_ld_way] = f_ld_cmp;
        m_rpw[0][f_ld_ea[19:15]][f_ld_way] = f_ld_rpw;
      end
      if (d_ld) begin
        m_vld[1][d_ld_ea[19:15]][d_ld_way] = d_ld_cmp[31];
        m_cmp[1][d_ld_ea[19:15]][d_ld_way] = d_ld_cmp;
        m_rpw[1][d_ld_ea[19:15]][d_ld_way] = d_ld_rpw;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare("fetch", tf, {f_rsp_valid, f_hit, f_miss, f_kind, f_pa, f_rpw}, ef);
    compare("data",  td, {d_rsp_valid, d_hit, d_miss, d_kind, d_pa, d_rpw}, ed);
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  logic [31:0] ea3, ea7, ea9, cA, cB, cC, cD, cE, cF, rA, rB, rC, rD1, rD2, rE;

  initial begin
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 32; i++)
        for (int w = 0; w < 2; w++) begin
          m_vld[s][i][w] = 1'b0; m_cmp[s][i][w] = '0; m_rpw[s][i][w] = '0;
        end
    idle();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    ea3 = mk_ea(12'hFFF, 5'd3, 15'h0ABC);
    ea7 = mk_ea(12'h123, 5'd7, 15'h7456);
    ea9 = mk_ea(12'h0F0, 5'd9, 15'h0001);
    cA = mk_cmp(1, 24'hABCDE1, 0, 6'h15);
    cB = mk_cmp(1, 24'h00BEEF, 1, 6'h2A);
    cC = mk_cmp(1, 24'h00BEEF, 0, 6'h2A);
    cD = mk_cmp(1, 24'h777777, 1, 6'h01);
    cE = mk_cmp(1, 24'h135791, 0, 6'h3F);
    cF = mk_cmp(1, 24'h246802, 1, 6'h00);
    rA  = mk_rpw(20'h12345, 1, 4'h3, 2'b10);
    rB  = mk_rpw(20'hA0B0C, 1, 4'h5, 2'b01);
    rC  = mk_rpw(20'h00C0D, 0, 4'h0, 2'b11);
    rD1 = mk_rpw(20'h11111, 1, 4'h1, 2'b00);
    rD2 = mk_rpw(20'h22222, 1, 4'h2, 2'b01);
    rE  = mk_rpw(20'hFEDCB, 1, 4'hF, 2'b10);

    // R1: empty after reset
    tick("R1");
    fq(ea3, cA); dq(ea3, cA, 0); tick("R1");

    // R5 then R3 (lookup valid bit ignored) and R4
    fl(ea3, 0, cA, rA); tick("R5");
    fq(ea3, {1'b0, cA[30:0]}); tick("R3");
    fq(mk_ea(12'h000, 5'd3, 15'h0FFF), cA); tick("R4");

    // R6: data side never sees the fetch load
    dq(ea3, cA, 0); tick("R6");
    dq(ea3, cA, 1); tick("R7");

    // data entries, one with changed bit set and one clear
    dl(ea7, 1, cB, rB); tick("R5");
    dl(ea7, 0, cC, rC); tick("R5");
    dq(ea7, cB, 0); tick("R7");
    dq(ea7, cB, 1); tick("R7");
    dq(ea7, cC, 0); tick("R8");
    dq(ea7, cC, 1); tick("R8");
    fq(ea7, cB); tick("R6");

    // field mismatches and wrong set
    dq(ea7, mk_cmp(1, 24'h00BEEE, 1, 6'h2A), 0); tick("R12");
    dq(ea7, mk_cmp(1, 24'h00BEEF, 1, 6'h2B), 0); tick("R3");
    dq(ea9, cB, 0); tick("R5");

    // R11: duplicate match, way 0 wins
    dl(ea9, 0, cD, rD1); tick("R5");
    dl(ea9, 1, cD, rD2); tick("R5");
    dq(ea9, cD, 0); tick("R11");

    // R10: load and lookup together on the fetch side
    fl(ea3, 1, cE, rE); fq(ea3, cA); dq(ea9, cD, 1); tick("R10");
    fq(ea3, cE); tick("R10");

    // loading a word with valid bit clear leaves the entry invalid
    fl(ea3, 0, {1'b0, cA[30:0]}, rA); tick("R5");
    fq(ea3, cA); tick("R5");

    // R9: lookup in the clearing cycle sees old contents, load is dropped
    inv_all = 1; fq(ea3, cE); dl(ea7, 0, cF, rB); tick("R9");
    dq(ea7, cF, 0); tick("R9");
    fq(ea3, cE); dq(ea7, cB, 0); tick("R9");

    // random traffic over two sets and a small word pool
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] pc;
      logic [4:0]  st;
      st = ($urandom % 2) ? 5'd3 : 5'd7;
      pc = mk_cmp(1'b1, 24'h5A0000 + 24'($urandom % 4), 1'b0, 6'h11);
      if ($urandom % 3 == 0)
        fl(mk_ea(12'($urandom), st, 15'($urandom)), 1'($urandom),
           {1'($urandom % 8 != 0), pc[30:0]}, mk_rpw(20'($urandom), 1'($urandom), 4'($urandom), 2'($urandom)));
      if ($urandom % 3 == 0)
        dl(mk_ea(12'($urandom), st, 15'($urandom)), 1'($urandom),
           {1'($urandom % 8 != 0), pc[30:0]}, mk_rpw(20'($urandom), 1'($urandom), 4'($urandom), 2'($urandom)));
      st = ($urandom % 2) ? 5'd3 : 5'd7;
      pc = mk_cmp(1'($urandom), 24'h5A0000 + 24'($urandom % 4), 1'b0, 6'h11);
      if ($urandom % 4 != 0) fq(mk_ea(12'($urandom), st, 15'($urandom)), pc);
      if ($urandom % 4 != 0) dq(mk_ea(12'($urandom), st, 15'($urandom)), pc, 1'($urandom));
      if ($urandom % 64 == 0) inv_all = 1;
      tick("");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule